// File: doc/BRIEF.md
# Masked Acquisition Compare Engine

This block checks a finished state acquisition against a reference image, row by row and bit by bit. The image sits in a separate buffer as two planes: a value plane, and a care plane whose cleared bits mark don't-care positions. A per-channel enable vector removes whole columns from the check. A lower and an upper row bound limit the rows that are visited. For each visited row the engine emits the vector of differing bits, so a viewer can highlight them. At the end it reports the total count of differing rows, the index of the first one, whether the acquisition matched, and whether a repetitive acquisition loop should halt. The halt rule is either "halt when equal" or "halt when not equal".

Both memories are reached through one shared synchronous read address with one cycle of latency. A copy operation loads the image from the current acquisition: every row's value plane takes the acquired data, and every care bit is set. Two separate pulses start the operations: one runs a compare and the other runs a copy. While either operation is busy, further requests are dropped.

Top module: `acq_cmp_engine`

## Requirements
- R1: After reset the engine is idle: busy_o=0, done_o=0, diff_vld_o=0, equal_o=1, halt_o=0, mis_cnt_o=0.
- R2: For each row r in the window, one cycle with diff_vld_o=1 carries diff_row_o=r and diff_vec_o=(acq XOR value) AND care AND ch_en. Rows come out in ascending order.
- R3: An image bit whose care bit is 0 never produces a difference, whatever the acquired bit is.
- R4: A channel whose ch_en_i bit is 0 never produces a difference in any row.
- R5: Only rows with row_lo_i <= r <= row_hi_i are compared, and rows outside the window do not affect the result. When row_lo_i > row_hi_i, no row is visited and the result is equal.
- R6: done_o is a single-cycle pulse in the cycle after the last window row's diff_vld_o, or two cycles after the start pulse for an empty window. busy_o is 0 in that cycle. From the pulse until the next compare start, mis_cnt_o holds the number of rows with a nonzero difference, equal_o is 1 exactly when that count is 0, and first_row_o holds the lowest differing row whenever the count is nonzero.
- R7: With stop_on_eq_i=1 latched at start, halt_o=equal_o. With stop_on_eq_i=0, halt_o=!equal_o.
- R8: A copy writes every row 0..2^ROW_W-1 once, with value=acquired data and care all ones. It does not pulse done_o, and a following full-window compare reports equal.
- R9: start_i or copy_i sampled while busy_o=1 is ignored: the running compare's results are unchanged and the image is not rewritten.
- R10: ch_en_i, row_lo_i, row_hi_i and stop_on_eq_i are sampled only with an accepted start_i. Changing them during a compare has no effect on that compare. start_i takes priority over copy_i when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a compare when idle |
| copy_i | input | 1 | Start an image copy when idle |
| ch_en_i | input | CH_W | Per-channel compare enable |
| row_lo_i | input | ROW_W | Lowest row compared |
| row_hi_i | input | ROW_W | Highest row compared |
| stop_on_eq_i | input | 1 | 1: halt on equal, 0: halt on not equal |
| rd_addr_o | output | ROW_W | Shared read address of both memories |
| acq_data_i | input | CH_W | Acquisition row, one cycle after address |
| img_val_i | input | CH_W | Image value plane, one cycle after address |
| img_care_i | input | CH_W | Image care plane, one cycle after address |
| img_we_o | output | 1 | Image write strobe during copy |
| img_waddr_o | output | ROW_W | Image write address |
| img_wval_o | output | CH_W | Image value write data |
| img_wcare_o | output | CH_W | Image care write data |
| busy_o | output | 1 | Operation in progress |
| diff_vld_o | output | 1 | Per-row difference valid |
| diff_row_o | output | ROW_W | Row of the difference vector |
| diff_vec_o | output | CH_W | Per-row differing bits |
| done_o | output | 1 | Compare finished pulse |
| equal_o | output | 1 | No differing row found |
| halt_o | output | 1 | Repetitive-run halt decision |
| first_row_o | output | ROW_W | First differing row |
| mis_cnt_o | output | ROW_W+1 | Number of differing rows |

## Verification
The hardest case to reach is a second request arriving in the middle of a compare with different settings. Dropping it must leave the latched window, channel mask and halt rule untouched, and a copy that slipped in would silently rewrite the image. The bench starts a full compare while the image deliberately differs from the acquisition in one row. A few cycles later it raises start and copy together with a narrowed window, no enabled channels and the opposite halt rule. It then checks both the streamed per-row vectors and the image contents afterwards. A separate sequence layers a don't-care bit over one injected flip and a disabled column over another, so that each masking path is seen to remove exactly one mismatch.

// File: rtl/acq_cmp_pkg.sv
package acq_cmp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_CMP  = 2'd1,
    OP_COPY = 2'd2
  } op_e;
endpackage

// File: rtl/acq_cmp_seq.sv
module acq_cmp_seq
  import acq_cmp_pkg::*;
#(
  parameter int ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  op_e              op_i,
  input  logic [ROW_W-1:0] lo_i,
  input  logic [ROW_W-1:0] hi_i,
  output logic             iss_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             last_o,
  output logic             empty_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

  logic             iss_q;
  logic [ROW_W-1:0] addr_q;
  logic [ROW_W-1:0] end_q;
  logic             empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_q   <= 1'b0;
      addr_q  <= '0;
      end_q   <= '0;
      empty_q <= 1'b0;
    end else begin
      empty_q <= 1'b0;
      if (go_i) begin
        if (op_i == OP_COPY) begin
          iss_q  <= 1'b1;
          addr_q <= '0;
          end_q  <= ROW_MAX;
        end else if (lo_i > hi_i) begin
          empty_q <= 1'b1;
        end else begin
          iss_q  <= 1'b1;
          addr_q <= lo_i;
          end_q  <= hi_i;
        end
      end else if (iss_q) begin
        if (addr_q == end_q) iss_q <= 1'b0;
        else addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign iss_o   = iss_q;
  assign addr_o  = addr_q;
  assign last_o  = (addr_q == end_q);
  assign empty_o = empty_q;
endmodule

// File: rtl/acq_cmp_diff.sv
module acq_cmp_diff #(
  parameter int CH_W = 16
) (
  input  logic [CH_W-1:0] acq_i,
  input  logic [CH_W-1:0] val_i,
  input  logic [CH_W-1:0] care_i,
  input  logic [CH_W-1:0] en_i,
  output logic [CH_W-1:0] diff_o,
  output logic            hit_o
);
  assign diff_o = (acq_i ^ val_i) & care_i & en_i;
  assign hit_o  = |diff_o;
endmodule

// File: rtl/acq_cmp_acc.sv
module acq_cmp_acc #(
  parameter int ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             hit_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W:0]   cnt_o,
  output logic [ROW_W-1:0] first_o,
  output logic             any_o
);
  logic [ROW_W:0]   cnt_q;
  logic [ROW_W-1:0] first_q;
  logic             any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= '0;
      any_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      first_q <= '0;
      any_q   <= 1'b0;
    end else if (upd_i && hit_i) begin
      cnt_q <= cnt_q + 1'b1;
      any_q <= 1'b1;
      if (!any_q) first_q <= row_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = first_q;
  assign any_o   = any_q;
endmodule

// File: rtl/acq_cmp_engine.sv
module acq_cmp_engine
  import acq_cmp_pkg::*;
#(
  parameter int CH_W  = 16,
  parameter int ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             copy_i,
  input  logic [CH_W-1:0]  ch_en_i,
  input  logic [ROW_W-1:0] row_lo_i,
  input  logic [ROW_W-1:0] row_hi_i,
  input  logic             stop_on_eq_i,
  output logic [ROW_W-1:0] rd_addr_o,
  input  logic [CH_W-1:0]  acq_data_i,
  input  logic [CH_W-1:0]  img_val_i,
  input  logic [CH_W-1:0]  img_care_i,
  output logic             img_we_o,
  output logic [ROW_W-1:0] img_waddr_o,
  output logic [CH_W-1:0]  img_wval_o,
  output logic [CH_W-1:0]  img_wcare_o,
  output logic             busy_o,
  output logic             diff_vld_o,
  output logic [ROW_W-1:0] diff_row_o,
  output logic [CH_W-1:0]  diff_vec_o,
  output logic             done_o,
  output logic             equal_o,
  output logic             halt_o,
  output logic [ROW_W-1:0] first_row_o,
  output logic [ROW_W:0]   mis_cnt_o
);
  logic             busy_q;
  op_e              op_q;
  logic [CH_W-1:0]  en_q;
  logic [ROW_W-1:0] lo_q, hi_q;
  logic             stop_q;

  logic             go;
  op_e              go_op;
  logic             iss, last, empty;
  logic [ROW_W-1:0] addr;

  logic             vld_q, last_q, done_q;
  logic [ROW_W-1:0] row_q;
  logic [CH_W-1:0]  diff;
  logic             hit, any;
  logic             fin, is_cmp;

  assign go     = !busy_q && (start_i || copy_i);
  assign go_op  = start_i ? OP_CMP : OP_COPY;
  assign is_cmp = (op_q == OP_CMP);
  assign fin    = (vld_q && last_q) || empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      en_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      stop_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      op_q   <= go_op;
      if (start_i) begin
        en_q   <= ch_en_i;
        lo_q   <= row_lo_i;
        hi_q   <= row_hi_i;
        stop_q <= stop_on_eq_i;
      end
    end else if (busy_q && fin) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
    end
  end

  acq_cmp_seq #(.ROW_W(ROW_W)) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .op_i    (go_op),
    .lo_i    (row_lo_i),
    .hi_i    (row_hi_i),
    .iss_o   (iss),
    .addr_o  (addr),
    .last_o  (last),
    .empty_o (empty)
  );

  // memories answer one cycle after the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= iss;
      last_q <= last;
      row_q  <= addr;
      done_q <= (vld_q && last_q && is_cmp) || empty;
    end
  end

  acq_cmp_diff #(.CH_W(CH_W)) diff_i (
    .acq_i  (acq_data_i),
    .val_i  (img_val_i),
    .care_i (img_care_i),
    .en_i   (en_q),
    .diff_o (diff),
    .hit_o  (hit)
  );

  acq_cmp_acc #(.ROW_W(ROW_W)) acc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go && start_i),
    .upd_i   (diff_vld_o),
    .hit_i   (hit),
    .row_i   (row_q),
    .cnt_o   (mis_cnt_o),
    .first_o (first_row_o),
    .any_o   (any)
  );

  assign rd_addr_o   = addr;
  assign img_we_o    = vld_q && (op_q == OP_COPY);
  assign img_waddr_o = row_q;
  assign img_wval_o  = acq_data_i;
  assign img_wcare_o = {CH_W{1'b1}};

  assign busy_o     = busy_q;
  assign diff_vld_o = vld_q && is_cmp;
  assign diff_row_o = row_q;
  assign diff_vec_o = diff_vld_o ? diff : '0;
  assign done_o     = done_q;
  assign equal_o    = !any;
  assign halt_o     = stop_q ? !any : any;
endmodule

// File: rtl/acq_cmp_engine_chk.sv
module acq_cmp_engine_chk #(
  parameter int CH_W  = 16,
  parameter int ROW_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             copy_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             diff_vld_o,
  input logic [ROW_W-1:0] diff_row_o,
  input logic [CH_W-1:0]  diff_vec_o,
  input logic             img_we_o,
  input logic             equal_o,
  input logic [ROW_W:0]   mis_cnt_o,
  input logic [CH_W-1:0]  en_q,
  input logic [ROW_W-1:0] lo_q,
  input logic [ROW_W-1:0] hi_q
);
  p_row_ascend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o && $past(diff_vld_o) |-> diff_row_o == ROW_W'($past(diff_row_o) + 1'b1));

  p_chan_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |-> (diff_vec_o & ~en_q) == '0);

  p_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |-> (diff_row_o >= lo_q) && (diff_row_o <= hi_q));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !diff_vld_o);

  p_eq_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> equal_o == (mis_cnt_o == '0));

  p_no_write_cmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |-> !img_we_o);

  p_busy_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i || copy_i));
endmodule

bind acq_cmp_engine acq_cmp_engine_chk #(.CH_W(CH_W), .ROW_W(ROW_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .copy_i     (copy_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .diff_vld_o (diff_vld_o),
  .diff_row_o (diff_row_o),
  .diff_vec_o (diff_vec_o),
  .img_we_o   (img_we_o),
  .equal_o    (equal_o),
  .mis_cnt_o  (mis_cnt_o),
  .en_q       (en_q),
  .lo_q       (lo_q),
  .hi_q       (hi_q)
);

// File: tb/acq_cmp_engine_tb_top.sv
`timescale 1ns/1ps
module acq_cmp_engine_tb_top;
  localparam int CH_W  = 16;
  localparam int ROW_W = 5;
  localparam int DEPTH = 1 << ROW_W;
  localparam logic [CH_W-1:0] ALL = {CH_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start, copy, stop_eq;
  logic [CH_W-1:0]  ch_en;
  logic [ROW_W-1:0] lo, hi;
  logic [ROW_W-1:0] rd_addr, img_waddr, diff_row, first_row;
  logic [CH_W-1:0]  acq_rd, val_rd, care_rd, img_wval, img_wcare, diff_vec;
  logic             img_we, busy, diff_vld, done, equal, halt;
  logic [ROW_W:0]   mis_cnt;

  logic [CH_W-1:0] acq_m [DEPTH];
  logic [CH_W-1:0] img_v [DEPTH];
  logic [CH_W-1:0] img_c [DEPTH];

  int checks = 0;
  int errors = 0;
  int wd = 0;
  int we_cnt = 0;

  acq_cmp_engine #(.CH_W(CH_W), .ROW_W(ROW_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .copy_i(copy),
    .ch_en_i(ch_en), .row_lo_i(lo), .row_hi_i(hi), .stop_on_eq_i(stop_eq),
    .rd_addr_o(rd_addr), .acq_data_i(acq_rd), .img_val_i(val_rd), .img_care_i(care_rd),
    .img_we_o(img_we), .img_waddr_o(img_waddr), .img_wval_o(img_wval), .img_wcare_o(img_wcare),
    .busy_o(busy), .diff_vld_o(diff_vld), .diff_row_o(diff_row), .diff_vec_o(diff_vec),
    .done_o(done), .equal_o(equal), .halt_o(halt), .first_row_o(first_row), .mis_cnt_o(mis_cnt)
  );

  always @(posedge clk) begin
    acq_rd  <= acq_m[rd_addr];
    val_rd  <= img_v[rd_addr];
    care_rd <= img_c[rd_addr];
    if (img_we) begin
      img_v[img_waddr] <= img_wval;
      img_c[img_waddr] <= img_wcare;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      finish_run();
    end
  end

  // full compare: model computed from bench arrays, per-row stream checked
  task automatic run_cmp(input int l, input int h, input logic [CH_W-1:0] en,
                         input logic s_eq, input bit poke, input string req);
    int e_cnt = 0, e_first = -1, nxt = l, seen = 0, n_win, cyc = 0;
    bit e_eq;
    logic [CH_W-1:0] e_vec;
    for (int r = 0; r < DEPTH; r++) begin
      if (r >= l && r <= h) begin
        e_vec = (acq_m[r] ^ img_v[r]) & img_c[r] & en;
        if (e_vec != '0) begin
          e_cnt++;
          if (e_first < 0) e_first = r;
        end
      end
    end
    e_eq  = (e_cnt == 0);
    n_win = (l > h) ? 0 : h - l + 1;
    @(negedge clk);
    lo = ROW_W'(l); hi = ROW_W'(h); ch_en = en; stop_eq = s_eq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; copy = 1'b1; lo = ROW_W'(h); ch_en = '0; stop_eq = ~s_eq;
      end else if (poke && cyc == 4) begin
        start = 1'b0; copy = 1'b0;
      end
      if (diff_vld) begin
        e_vec = (acq_m[diff_row] ^ img_v[diff_row]) & img_c[diff_row] & en;
        chk(diff_row == ROW_W'(nxt), req, "diff_row", diff_row, nxt);
        chk(diff_vec == e_vec, req, "diff_vec", diff_vec, e_vec);
        nxt++;
        seen++;
      end
    end
    chk(done, "R6", "done seen", done, 1);
    chk(!busy, "R6", "busy at done", busy, 0);
    chk(seen == n_win, "R5", "rows visited", seen, n_win);
    chk(mis_cnt == e_cnt, req, "mis_cnt", mis_cnt, e_cnt);
    chk(equal == e_eq, req, "equal", equal, e_eq);
    chk(halt == (s_eq ? e_eq : !e_eq), "R7", "halt", halt, s_eq ? e_eq : !e_eq);
    if (e_cnt > 0) chk(first_row == ROW_W'(e_first), req, "first_row", first_row, e_first);
    @(negedge clk);
    chk(!done, "R6", "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !diff_vld, "R1", "idle flags", {busy, done, diff_vld}, 0);
    chk(equal && !halt, "R1", "equal/halt", {equal, halt}, 2'b10);
    chk(mis_cnt == 0, "R1", "mis_cnt", mis_cnt, 0);
  endtask

  task automatic t_copy();
    int dn = 0, cyc = 0, w0;
    bit ok = 1;
    w0 = we_cnt;
    @(negedge clk);
    copy = 1'b1;
    @(negedge clk);
    copy = 1'b0;
    while ((busy || cyc == 0) && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (done) dn++;
    end
    @(negedge clk);
    for (int r = 0; r < DEPTH; r++)
      if (img_v[r] != acq_m[r] || img_c[r] != ALL) ok = 0;
    chk(ok, "R8", "image rows after copy", ok, 1);
    chk(we_cnt - w0 == DEPTH, "R8", "write count", we_cnt - w0, DEPTH);
    chk(dn == 0, "R8", "no done on copy", dn, 0);
    run_cmp(0, DEPTH - 1, ALL, 1'b1, 0, "R8");
  endtask

  task automatic t_flip();
    acq_m[5] = acq_m[5] ^ CH_W'(1 << 3);
    acq_m[9] = acq_m[9] ^ CH_W'(1 << 7);
    run_cmp(0, DEPTH - 1, ALL, 1'b0, 0, "R2");
  endtask

  task automatic t_xbits();
    @(negedge clk);
    img_c[5] <= img_c[5] & ~CH_W'(1 << 3);
    @(negedge clk);
    run_cmp(0, DEPTH - 1, ALL, 1'b1, 0, "R3");
    chk(first_row == 9, "R3", "x bit skipped", first_row, 9);
  endtask

  task automatic t_chan();
    run_cmp(0, DEPTH - 1, ~CH_W'(1 << 7), 1'b1, 0, "R4");
    chk(equal, "R4", "disabled column", equal, 1);
  endtask

  task automatic t_window();
    run_cmp(6, 20, ALL, 1'b0, 0, "R5");
    run_cmp(10, DEPTH - 1, ALL, 1'b0, 0, "R5");
    run_cmp(12, 4, ALL, 1'b0, 0, "R5");
    run_cmp(9, 9, ALL, 1'b1, 0, "R5");
  endtask

  task automatic t_busy();
    int w0;
    logic [CH_W-1:0] v9, c5;
    w0 = we_cnt; v9 = img_v[9]; c5 = img_c[5];
    run_cmp(0, DEPTH - 1, ALL, 1'b1, 1, "R9");
    chk(we_cnt == w0, "R9", "no image write", we_cnt - w0, 0);
    chk(img_v[9] == v9 && img_c[5] == c5, "R9", "image kept", img_v[9], v9);
    chk(mis_cnt == 1, "R10", "latched config", mis_cnt, 1);
  endtask

  task automatic t_prio();
    int w0;
    w0 = we_cnt;
    @(negedge clk);
    lo = 0; hi = ROW_W'(DEPTH - 1); ch_en = ALL; stop_eq = 1'b0;
    start = 1'b1; copy = 1'b1;
    @(negedge clk);
    start = 1'b0; copy = 1'b0;
    for (int i = 0; i < DEPTH + 4; i++) @(negedge clk);
    chk(we_cnt == w0, "R10", "start wins over copy", we_cnt - w0, 0);
    chk(mis_cnt == 1 && halt, "R10", "compare ran", mis_cnt, 1);
  endtask

  initial begin
    start = 0; copy = 0; stop_eq = 0; ch_en = '0; lo = '0; hi = '0;
    for (int r = 0; r < DEPTH; r++) begin
      acq_m[r] = CH_W'(r * 16'h1357) ^ CH_W'(16'hA5C3);
      img_v[r] = ~acq_m[r];
      img_c[r] = ALL;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_flip();
    t_xbits();
    t_chan();
    t_window();
    t_busy();
    t_prio();
    finish_run();
  end
endmodule